// File: doc/BRIEF.md
# Key-Guarded Cache SRAM Power Controller

This block holds the power state of a cache SRAM that forms one power partition, and it decides when that SRAM can safely be used. Software sets the state through a 32-bit register. The register changes only when the upper half of the write data carries a fixed guard key. Any write without the key leaves the register exactly as it was. On readback the upper half always shows a fixed tag that differs from the key, the unused middle bits show zero, and the two low bits show the stored mode.

When the SRAM enters the enabled state, a power-up sequencer starts counting single-cycle slow-clock tick pulses in the fast clock domain. It raises a ready flag once the count reaches a programmed delay. The cache enable is guarded by that flag. A request to turn the cache on is honoured only while the SRAM is enabled and ready. A premature request is dropped and sets a sticky error flag. The intended software order is to clear the cache enable before powering off, and to wait for ready after powering on before setting the cache enable.

Top module: `mpc_top`

## Requirements
- R1: After reset the stored mode is 3 (enabled), `rd_data` reads 0xFA050003, `cache_en` and `seq_err` are 0, and the power-up count starts from zero.
- R2: A write whose bits [31:16] equal 0x05FA stores bits [1:0] as the mode, with encodings 0 = off, 1 = reserved, 2 = retained, 3 = enabled. The new value is visible on `rd_data[1:0]` in the cycle after the write.
- R3: A write whose bits [31:16] differ from 0x05FA changes nothing.
- R4: `rd_data[31:16]` always reads 0xFA05 and `rd_data[15:2]` always reads zero, whatever was written.
- R5: `pwr_state` shows the stored mode, except that a stored reserved value 1 is shown as 0 (off). `rd_data[1:0]` still returns 1 in that case.
- R6: `sram_ready` is 1 only while the mode is enabled and the number of `slow_tick` pulses counted since entering that mode is at least `pwrup_dly`. Ticks are not counted while the mode is anything other than enabled. A tick that arrives in the same cycle as the write entering the enabled state is not counted.
- R7: An accepted write of any mode other than 3 drops `sram_ready` in the next cycle. A later entry into the enabled state restarts the count from zero.
- R8: A `cen_set` pulse while `sram_ready` is 1 sets `cache_en` in the next cycle.
- R9: A `cen_set` pulse while `sram_ready` is 0 leaves `cache_en` unchanged and sets `seq_err`. `seq_err` stays set until reset.
- R10: `cen_clr` clears `cache_en` in the next cycle and takes priority over a simultaneous `cen_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data: guard key in [31:16], mode in [1:0] |
| rd_data | output | 32 | Register readback |
| slow_tick | input | 1 | One-cycle pulse per slow-clock period |
| pwrup_dly | input | DLY_W | Power-up delay in slow ticks |
| cen_set | input | 1 | Request to set the cache enable |
| cen_clr | input | 1 | Request to clear the cache enable |
| pwr_state | output | 2 | Effective power state (reserved shown as off) |
| sram_ready | output | 1 | SRAM powered and delay elapsed |
| cache_en | output | 1 | Cache enable |
| seq_err | output | 1 | Sticky flag for an out-of-order enable request |

## Verification
The assertions check several properties on every cycle:
- a write without the key leaves the mode stable;
- the reserved code never reaches `pwr_state`;
- ready never appears outside the enabled state;
- the power-up count moves by at most one per cycle while enabled;
- a rising cache enable is always preceded by ready;
- the error flag never clears;
- a clear request always wins.

The exact number of ticks before ready, the restart of the count after leaving and re-entering the enabled state, and the readback pattern for every combination of key and mode can be shown only by the bench's sweeps over delay values and write patterns.

// File: rtl/mpc_pkg.sv
// Shared constants and types for the cache SRAM power controller.
// Assumes the 32-bit register layout: key/tag in [31:16], mode in [1:0].
package mpc_pkg;
    typedef enum logic [1:0] {
        PM_OFF  = 2'd0,
        PM_RSVD = 2'd1,
        PM_RET  = 2'd2,
        PM_ON   = 2'd3
    } pmode_t;

    localparam logic [15:0] WR_KEY = 16'h05FA;
    localparam logic [15:0] RD_TAG = 16'hFA05;
    localparam int          PAD_W  = 14;
endpackage

// File: rtl/mpc_keyreg.sv
// Guarded mode register: stores the 2-bit power mode on writes that carry
// the guard key and builds the fixed readback word.
// Assumes wr_en is a single-cycle strobe in the clk domain.
module mpc_keyreg
    import mpc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output pmode_t      mode,
    output logic [31:0] rd_data
);
    logic key_ok;

    // Decode whether the write carries the guard key.
    always_comb key_ok = (wr_data[31:16] == WR_KEY);

    // Mode storage; a write without the key is discarded.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= PM_ON;
        else if (wr_en && key_ok)
            mode <= pmode_t'(wr_data[1:0]);
    end

    // Readback: fixed tag, zero padding, stored mode.
    always_comb rd_data = {RD_TAG, {PAD_W{1'b0}}, mode};

    AST_KEY_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_data[31:16] != WR_KEY)) |=> $stable(mode)); // R3
endmodule

// File: rtl/mpc_pwrup_cnt.sv
// Power-up sequencer: counts slow-clock tick pulses while the SRAM is in
// the enabled mode and flags ready once the programmed delay is reached.
// Assumes slow_tick is a one-cycle pulse synchronous to clk.
module mpc_pwrup_cnt #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_on,
    input  logic             slow_tick,
    input  logic [DLY_W-1:0] dly,
    output logic             ready
);
    logic [DLY_W-1:0] cnt;
    logic             done;

    // Delay reached when the count has caught up with the programmed value.
    always_comb done = (cnt >= dly);

    // Tick counter; held at zero outside the enabled mode, saturates at dly.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!mode_on)
            cnt <= '0;
        else if (slow_tick && !done)
            cnt <= cnt + 1'b1;
    end

    // Ready requires both the enabled mode and the elapsed delay.
    always_comb ready = mode_on && done;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_on && $past(mode_on)) |->
            ((cnt == $past(cnt)) || (cnt == DLY_W'($past(cnt) + 1'b1)))); // R6
endmodule

// File: rtl/mpc_cen_gate.sv
// Cache-enable gate: accepts an enable request only while the SRAM is
// ready, flags premature requests, and lets a clear request win.
// Assumes cen_set / cen_clr are single-cycle pulses in the clk domain.
module mpc_cen_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic ready,
    input  logic cen_set,
    input  logic cen_clr,
    output logic cache_en,
    output logic seq_err
);
    // Cache enable flop: clear has priority, set only when ready.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cache_en <= 1'b0;
        else if (cen_clr)
            cache_en <= 1'b0;
        else if (cen_set && ready)
            cache_en <= 1'b1;
    end

    // Sticky error on any enable request made before ready.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seq_err <= 1'b0;
        else if (cen_set && !ready)
            seq_err <= 1'b1;
    end

    AST_CEN_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cache_en) |-> $past(ready)); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> seq_err); // R9
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cen_clr |=> !cache_en); // R10
endmodule

// File: rtl/mpc_top.sv
// Cache SRAM power controller top: guarded mode register, power-up
// sequencer and cache-enable gate. The reserved mode code is reported
// as off on the power-state output.
// Assumes all inputs are synchronous to clk.
module mpc_top
    import mpc_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    output logic [31:0]      rd_data,
    input  logic             slow_tick,
    input  logic [DLY_W-1:0] pwrup_dly,
    input  logic             cen_set,
    input  logic             cen_clr,
    output logic [1:0]       pwr_state,
    output logic             sram_ready,
    output logic             cache_en,
    output logic             seq_err
);
    pmode_t mode;
    logic   mode_on;

    mpc_keyreg u_keyreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .mode    (mode),
        .rd_data (rd_data)
    );

    // Enabled-mode decode feeding the sequencer.
    always_comb mode_on = (mode == PM_ON);

    // Effective power state: reserved code collapses to off.
    always_comb pwr_state = (mode == PM_RSVD) ? PM_OFF : mode;

    mpc_pwrup_cnt #(.DLY_W(DLY_W)) u_pwrup (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_on   (mode_on),
        .slow_tick (slow_tick),
        .dly       (pwrup_dly),
        .ready     (sram_ready)
    );

    mpc_cen_gate u_cen (
        .clk      (clk),
        .rst_n    (rst_n),
        .ready    (sram_ready),
        .cen_set  (cen_set),
        .cen_clr  (cen_clr),
        .cache_en (cache_en),
        .seq_err  (seq_err)
    );

    AST_NO_RSVD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_state != 2'd1); // R5
    AST_READY_ONLY_ON: assert property (@(posedge clk) disable iff (!rst_n)
        sram_ready |-> (pwr_state == 2'd3)); // R6
    AST_LEAVE_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_data[31:16] == WR_KEY) && (wr_data[1:0] != 2'd3))
            |=> !sram_ready); // R7
endmodule

// File: tb/test_mpc_top.sv
module test_mpc_top;
    localparam int DLY_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [31:0]      wr_data = '0;
    logic [31:0]      rd_data;
    logic             slow_tick = 1'b0;
    logic [DLY_W-1:0] pwrup_dly = '0;
    logic             cen_set = 1'b0;
    logic             cen_clr = 1'b0;
    logic [1:0]       pwr_state;
    logic             sram_ready;
    logic             cache_en;
    logic             seq_err;

    int total = 0;
    int bad = 0;

    mpc_top #(.DLY_W(DLY_W)) i_mpc_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .slow_tick(slow_tick), .pwrup_dly(pwrup_dly),
        .cen_set(cen_set), .cen_clr(cen_clr), .pwr_state(pwr_state),
        .sram_ready(sram_ready), .cache_en(cache_en), .seq_err(seq_err)
    );

    always #2 clk = ~clk;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_write(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        slow_tick = 1'b1;
        @(negedge clk);
        slow_tick = 1'b0;
    endtask

    task automatic do_cen(input logic s, input logic c);
        @(negedge clk);
        cen_set = s;
        cen_clr = c;
        @(negedge clk);
        cen_set = 1'b0;
        cen_clr = 1'b0;
    endtask

    function automatic logic [31:0] rd_exp(input logic [1:0] m);
        return {16'hFA05, 14'd0, m};
    endfunction

    initial begin
        #(200000 * 4);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        pwrup_dly = 8'd3;
        do_reset();
        check(rd_data, 32'hFA050003, "R1 readback");
        check({30'd0, pwr_state}, 32'd3, "R1 pwr_state");
        check({31'd0, sram_ready}, 32'd0, "R1 ready");
        check({30'd0, cache_en, seq_err}, 32'd0, "R1 cen/err");

        // R6/R8/R9: delay sweep
        for (int d = 0; d <= 5; d++) begin
            do_reset();
            pwrup_dly = DLY_W'(d);
            do_write(32'h05FA_0000);
            check(rd_data, rd_exp(2'd0), "R2 off write");
            do_tick();
            do_tick();
            check({31'd0, sram_ready}, 32'd0, "R6 no count while off");
            do_write(32'h05FA_0003);
            for (int k = 0; k <= d + 1; k++) begin
                check({31'd0, sram_ready}, {31'd0, k >= d}, "R6 ready after ticks");
                if (k == 0 && d > 0) begin
                    do_cen(1'b1, 1'b0);
                    check({30'd0, cache_en, seq_err}, 32'd1, "R9 early set dropped");
                end
                @(negedge clk);
                check({31'd0, sram_ready}, {31'd0, k >= d}, "R6 idle cycle holds");
                do_tick();
            end
            do_cen(1'b1, 1'b0);
            check({31'd0, cache_en}, 32'd1, "R8 set when ready");
            check({31'd0, seq_err}, {31'd0, d > 0}, "R9 sticky error");
        end

        // R3/R4/R5: key x mode sweep
        pwrup_dly = 8'd0;
        do_reset();
        for (int m = 0; m < 4; m++) begin
            for (int kk = 0; kk < 4; kk++) begin
                logic [15:0] key;
                logic [1:0]  prev;
                logic [1:0]  exp_m;
                key = (kk == 0) ? 16'h05FA : (kk == 1) ? 16'hFA05 : (kk == 2) ? 16'h0000 : 16'h05FB;
                prev = 2'(m + 1);
                do_write({16'h05FA, 16'd0} | 32'(prev));
                do_write({key, 14'h3FFF, 2'(m)});
                exp_m = (kk == 0) ? 2'(m) : prev;
                check(rd_data, rd_exp(exp_m), (kk == 0) ? "R4 keyed readback" : "R3 bad key ignored");
                check({30'd0, pwr_state}, (exp_m == 2'd1) ? 32'd0 : 32'(exp_m), "R5 pwr_state map");
            end
        end

        // R7: leave and re-enter restarts the count
        pwrup_dly = 8'd3;
        do_reset();
        repeat (3) do_tick();
        check({31'd0, sram_ready}, 32'd1, "R6 ready after reset delay");
        do_write(32'h05FA_0002);
        check({31'd0, sram_ready}, 32'd0, "R7 retained drops ready");
        do_write(32'h05FA_0003);
        check({31'd0, sram_ready}, 32'd0, "R7 restart from zero");
        repeat (2) do_tick();
        check({31'd0, sram_ready}, 32'd0, "R7 two ticks not enough");
        do_tick();
        check({31'd0, sram_ready}, 32'd1, "R7 ready after full delay");
        do_write(32'h05FA_0001);
        check({31'd0, sram_ready}, 32'd0, "R7 reserved drops ready");

        // R10: clear priority
        do_write(32'h05FA_0003);
        repeat (3) do_tick();
        do_cen(1'b1, 1'b0);
        check({31'd0, cache_en}, 32'd1, "R8 set");
        do_cen(1'b1, 1'b1);
        check({31'd0, cache_en}, 32'd0, "R10 clear wins");
        do_cen(1'b1, 1'b0);
        do_cen(1'b0, 1'b1);
        check({31'd0, cache_en}, 32'd0, "R10 clear alone");
        check({31'd0, seq_err}, 32'd0, "R9 no error when ready");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule